// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Emulator

This block acts as the device side of a byte-wide parallel EEPROM. It is synthesizable and sits on a small on-chip byte array. A host drives chip-enable, write-enable and output-enable strobes, plus an address and a data byte. All strobes are brought into the system clock domain through two-stage synchronizers. The block then collects a page of byte loads into a buffer. After that it runs a programming phase of fixed length, and during this phase the host can poll it for completion.

A write cycle is the interval in which both chip-enable and write-enable are low. The address is taken when that interval opens and the data when it closes. The first accepted byte fixes the page. Later bytes are kept only when they fall in that same page. A page closes in one of two ways:

- the strobes stay inactive long enough after a data capture, or
- a new write cycle fails to open within the inter-byte window.

Closing the page starts programming. Programming is a fixed delay followed by a commit pass. The commit pass writes only the loaded bytes into the array.

During the busy period, reads return a polling byte and the busy pin pulls low. A protect input blocks all reads and all writes.

Top module: `eeprom_page_model`

## Requirements
- R1: After a data capture, when the strobes stay inactive for IDLE_CYC synchronized clock cycles, the page closes. Programming then runs for PROG_CYC cycles, followed by a commit pass of 64 cycles. After that, each loaded byte reads back from the array at its address.
- R2: The address is taken on the cycle in which the later of ceN and weN goes low, which is the opening of the write cycle. The data is taken on the cycle in which the first of the two goes high again.
- R3: A read during the busy period returns the last accepted data byte with bit 7 inverted and bits 6..0 unchanged. A read is ceN low, oeN low and weN high; while it lasts, dOutEn is high.
- R4: rdyBusyLow is 0 (high impedance) after reset and while idle. It becomes 1 (pulling low) once the first write cycle of a page opens. It returns to 0 only when the commit pass ends.
- R5: While protN is 0, write cycles start no page and change no byte, and reads leave dOutEn at 0 and dOut at 0.
- R6: Write cycles that open while programming or committing are ignored. They leave the array unchanged and do not start a new page afterwards.
- R7: The page is the address bits above bit 5 of the first byte. A later byte whose upper bits differ is not stored, and pageDrop goes to 1 until the next page starts.
- R8: Array bytes in the page that were not loaded keep their earlier contents after the commit pass.
- R9: Suppose a write cycle stays open so that no new one opens within WIN_CYC cycles of the last opening. The page then closes, programming starts, and the byte of the unfinished write cycle is discarded.
- R10: One page accepts all 64 offsets. All of them are committed and read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| protN | input | 1 | Protect, active low; blocks all access while 0 |
| addr | input | ADDR_W | Byte address |
| dIn | input | 8 | Write data |
| dOut | output | 8 | Read data or polling byte |
| dOutEn | output | 1 | Read data is being driven |
| rdyBusyLow | output | 1 | 1 = busy pin pulled low, 0 = high impedance |
| pageDrop | output | 1 | A byte outside the open page was rejected |

## Verification
Some properties are checked on every cycle by the assertions:

- the buffer's loaded-byte mask changes only on a capture strobe or at a page start, and a rejected out-of-page byte leaves it untouched;
- the busy pin is released only out of the commit pass;
- the inter-byte and commit counters stay within their bounds.

Other behaviour can only be shown by the bench's scenarios:

- which address and which data byte a skewed strobe pair actually stores;
- the polling byte's value;
- that unloaded, protected, out-of-page and busy-time writes leave old array contents intact;
- that a window violation discards the unfinished byte.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
  localparam int PAGE_BYTES = 64;
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_COMMIT
  } ee_state_t;

  typedef struct packed {
    logic              newPage;
    logic              capAddr;
    logic              capData;
    logic              commitEn;
    logic [PAGE_W-1:0] commitIdx;
  } ctrl_strb_t;
endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WIN_CYC  = 64,
  parameter int IDLE_CYC = 32,
  parameter int PROG_CYC = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ceN,
  input  logic       weN,
  input  logic       oeN,
  input  logic       protN,
  output ctrl_strb_t strb,
  output logic       busy,
  output logic       rdReq
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b0111;
  localparam int M1 = (WIN_CYC > IDLE_CYC) ? WIN_CYC : IDLE_CYC;
  localparam int M2 = (PROG_CYC > PAGE_BYTES) ? PROG_CYC : PAGE_BYTES;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WIN_LAST  = CNT_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_CYC - 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] PAGE_LAST = CNT_W'(PAGE_BYTES - 1);

  logic [NSYNC-1:0] rawVec, syncVec;
  assign rawVec = {protN, oeN, weN, ceN};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage <= {2{SYNC_RST[g]}};
      else        stage <= {stage[0], rawVec[g]};
    end
    assign syncVec[g] = stage[1];
  end

  logic ceS, weS, oeS, protS;
  assign {protS, oeS, weS, ceS} = syncVec;

  logic wrAct, wrActD, wrFall, wrRise;
  assign wrAct  = !ceS && !weS;
  assign wrFall = wrAct && !wrActD;
  assign wrRise = !wrAct && wrActD;

  ee_state_t state;
  logic [CNT_W-1:0] winCnt, idleCnt, progCnt;
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wrActD  <= 1'b0;
      winCnt  <= '0;
      idleCnt <= '0;
      progCnt <= '0;
      pending <= 1'b0;
    end else begin
      wrActD <= wrAct;
      case (state)
        ST_IDLE: begin
          if (wrFall && protS) begin
            state   <= ST_LOAD;
            winCnt  <= '0;
            idleCnt <= '0;
            pending <= 1'b1;
          end
        end
        ST_LOAD: begin
          winCnt  <= wrFall ? '0 : winCnt + CNT_W'(1);
          idleCnt <= wrAct ? '0 : idleCnt + CNT_W'(1);
          if (wrFall && protS) pending <= 1'b1;
          else if (wrRise)     pending <= 1'b0;
          if ((!wrAct && idleCnt == IDLE_LAST) || (!wrFall && winCnt == WIN_LAST)) begin
            state   <= ST_PROG;
            progCnt <= '0;
            pending <= 1'b0;
          end
        end
        ST_PROG: begin
          progCnt <= progCnt + CNT_W'(1);
          if (progCnt == PROG_LAST) begin
            state   <= ST_COMMIT;
            progCnt <= '0;
          end
        end
        default: begin
          progCnt <= progCnt + CNT_W'(1);
          if (progCnt == PAGE_LAST) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strb.newPage   = (state == ST_IDLE) && wrFall && protS;
    strb.capAddr   = ((state == ST_IDLE) || (state == ST_LOAD)) && wrFall && protS;
    strb.capData   = (state == ST_LOAD) && wrRise && pending && protS;
    strb.commitEn  = (state == ST_COMMIT);
    strb.commitIdx = progCnt[PAGE_W-1:0];
  end

  assign busy  = (state != ST_IDLE);
  assign rdReq = !ceS && !oeS && weS && protS;

  // R4: the busy pin is released only when a commit pass finishes
  a_r4_release_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(state) == ST_COMMIT);
  // R9: the inter-byte window counter never passes its limit while loading
  a_r9_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> (winCnt <= WIN_LAST));
  // R1: the commit pass covers exactly one page of offsets
  a_r1_commit_span: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COMMIT) |-> (progCnt <= PAGE_LAST));
endmodule

// File: rtl/eeprom_dpath.sv
module eeprom_dpath
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_strb_t        strb,
  input  logic              busy,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dIn,
  output logic [7:0]        dOut,
  output logic              dOutEn,
  output logic              dropFlag
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int UP_W  = ADDR_W - PAGE_W;

  logic [7:0]            mem     [DEPTH];
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [UP_W-1:0]       pageTag;
  logic [PAGE_W-1:0]     curOff;
  logic                  curOk;
  logic [7:0]            lastByte;

  logic [UP_W-1:0]   addrUp;
  logic [PAGE_W-1:0] addrLo;
  assign addrUp = addr[ADDR_W-1:PAGE_W];
  assign addrLo = addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validMask <= '0;
      pageTag   <= '0;
      curOff    <= '0;
      curOk     <= 1'b0;
      lastByte  <= '0;
      dropFlag  <= 1'b0;
    end else begin
      if (strb.newPage) begin
        pageTag   <= addrUp;
        validMask <= '0;
        dropFlag  <= 1'b0;
        curOk     <= 1'b1;
        curOff    <= addrLo;
      end else if (strb.capAddr) begin
        curOff <= addrLo;
        curOk  <= (addrUp == pageTag);
        if (addrUp != pageTag) dropFlag <= 1'b1;
      end
      if (strb.capData && curOk) begin
        validMask[curOff] <= 1'b1;
        lastByte          <= dIn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.capData && curOk) pageBuf[curOff] <= dIn;
  end

  always_ff @(posedge clk) begin
    if (strb.commitEn && validMask[strb.commitIdx])
      mem[{pageTag, strb.commitIdx}] <= pageBuf[strb.commitIdx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dOut   <= '0;
      dOutEn <= 1'b0;
    end else begin
      dOutEn <= rdReq;
      if (!rdReq)    dOut <= '0;
      else if (busy) dOut <= {~lastByte[7], lastByte[6:0]};
      else           dOut <= mem[addr];
    end
  end

  // R6: without a capture strobe or page start the loaded-byte mask holds
  a_r6_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.capData && !strb.newPage) |=> $stable(validMask));
  // R7: a byte rejected as out-of-page marks nothing as loaded
  a_r7_drop_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.capData && !curOk && !strb.newPage) |=> $stable(validMask));
endmodule

// File: rtl/eeprom_page_model.sv
module eeprom_page_model
  import eeprom_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int WIN_CYC  = 64,
  parameter int IDLE_CYC = 32,
  parameter int PROG_CYC = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              protN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dIn,
  output logic [7:0]        dOut,
  output logic              dOutEn,
  output logic              rdyBusyLow,
  output logic              pageDrop
);
  ctrl_strb_t strb;
  logic busy, rdReq;

  eeprom_ctrl #(
    .WIN_CYC (WIN_CYC),
    .IDLE_CYC(IDLE_CYC),
    .PROG_CYC(PROG_CYC)
  ) i_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .ceN  (ceN),
    .weN  (weN),
    .oeN  (oeN),
    .protN(protN),
    .strb (strb),
    .busy (busy),
    .rdReq(rdReq)
  );

  eeprom_dpath #(
    .ADDR_W(ADDR_W)
  ) i_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .busy    (busy),
    .rdReq   (rdReq),
    .addr    (addr),
    .dIn     (dIn),
    .dOut    (dOut),
    .dOutEn  (dOutEn),
    .dropFlag(pageDrop)
  );

  assign rdyBusyLow = busy;
endmodule

// File: tb/test_eeprom_page_model.sv
`timescale 1ns/1ps
module test_eeprom_page_model;
  localparam int AW = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ceN, weN, oeN, protN;
  logic [AW-1:0] addr;
  logic [7:0] dIn;
  logic [7:0] dOut;
  logic dOutEn, rdyBusyLow, pageDrop;

  eeprom_page_model #(.ADDR_W(AW)) i_eeprom_page_model (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .weN(weN), .oeN(oeN), .protN(protN),
    .addr(addr), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn),
    .rdyBusyLow(rdyBusyLow), .pageDrop(pageDrop)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    logic       en;
    string      req;
  } rd_item_t;
  rd_item_t sbq[$];
  logic smp = 1'b0;
  logic [7:0] refMem [1 << AW];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops an expected read and compares with the driven output
  always @(negedge clk) begin
    rd_item_t it;
    if (smp) begin
      if (sbq.size() == 0) begin
        check(1'b0, "scoreboard-empty", 0, 1);
      end else begin
        it = sbq.pop_front();
        check(dOutEn == it.en && dOut == it.exp, it.req, {dOutEn, dOut}, {it.en, it.exp});
      end
    end
  end

  task automatic writeByte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dIn = d; weN = 1'b0; ceN = 1'b0;
    repeat (4) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic readAt(input logic [AW-1:0] a, input logic [7:0] e, input logic en, input string req);
    rd_item_t it;
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    repeat (5) @(negedge clk);
    it.exp = e; it.en = en; it.req = req;
    sbq.push_back(it);
    @(posedge clk); smp = 1'b1;
    @(posedge clk); smp = 1'b0;
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic waitIdle(input string req);
    int n = 0;
    while (rdyBusyLow && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(n < 2000, req, n, 2000);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1; protN = 1'b1;
    addr = '0; dIn = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state, R7 flag clear
    check(rdyBusyLow == 1'b0, "R4 reset busy pin", rdyBusyLow, 0);
    check(dOutEn == 1'b0, "R3 reset dOutEn", dOutEn, 0);
    check(pageDrop == 1'b0, "R7 reset pageDrop", pageDrop, 0);
    repeat (4) @(negedge clk);

    // R10 / R1: full page at page 2
    for (int i = 0; i < 64; i++) begin
      writeByte(AW'(128 + i), 8'(i * 7 + 3));
      refMem[128 + i] = 8'(i * 7 + 3);
      if (i == 0) check(rdyBusyLow == 1'b1, "R4 busy after first write", rdyBusyLow, 1);
    end
    waitIdle("R1 page programmed");
    check(rdyBusyLow == 1'b0, "R4 released after commit", rdyBusyLow, 0);
    readAt(AW'(128), refMem[128], 1'b1, "R10 offset 0");
    readAt(AW'(159), refMem[159], 1'b1, "R10 offset 31");
    readAt(AW'(191), refMem[191], 1'b1, "R1 R10 offset 63");

    // R8 / R3: partial rewrite, poll while busy
    writeByte(AW'(131), 8'hA3); refMem[131] = 8'hA3;
    writeByte(AW'(138), 8'h3C); refMem[138] = 8'h3C;
    readAt(AW'(0), 8'hBC, 1'b1, "R3 polling byte");
    waitIdle("R8 partial page done");
    readAt(AW'(131), 8'hA3, 1'b1, "R8 loaded offset 3");
    readAt(AW'(138), 8'h3C, 1'b1, "R8 loaded offset 10");
    readAt(AW'(132), refMem[132], 1'b1, "R8 unloaded offset 4 kept");

    // pre-fill for later scenarios
    writeByte(AW'(448), 8'h77); refMem[448] = 8'h77;
    waitIdle("R1 prefill page 7");
    writeByte(AW'(577), 8'h19); refMem[577] = 8'h19;
    waitIdle("R1 prefill page 9");

    // R2: skewed strobes; address at later fall, data at first rise
    writeByte(AW'(321), 8'h11); refMem[321] = 8'h11;
    @(negedge clk);
    addr = AW'(321); dIn = 8'h00; weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = AW'(322);
    repeat (2) @(negedge clk);
    ceN = 1'b0;
    repeat (4) @(negedge clk);
    dIn = 8'h5D;
    repeat (2) @(negedge clk);
    ceN = 1'b1;
    repeat (4) @(negedge clk);
    dIn = 8'hE7;
    repeat (2) @(negedge clk);
    weN = 1'b1;
    refMem[322] = 8'h5D;
    waitIdle("R2 page done");
    readAt(AW'(322), 8'h5D, 1'b1, "R2 addr at last fall, data at first rise");
    readAt(AW'(321), 8'h11, 1'b1, "R2 early address untouched");

    // R7: out-of-page byte dropped
    writeByte(AW'(384), 8'h21); refMem[384] = 8'h21;
    writeByte(AW'(448), 8'h99);
    check(pageDrop == 1'b1, "R7 drop flag raised", pageDrop, 1);
    waitIdle("R7 page done");
    readAt(AW'(384), 8'h21, 1'b1, "R7 in-page byte stored");
    readAt(AW'(448), 8'h77, 1'b1, "R7 foreign page byte not stored");
    writeByte(AW'(385), 8'h22); refMem[385] = 8'h22;
    check(pageDrop == 1'b0, "R7 flag cleared on new page", pageDrop, 0);
    waitIdle("R7 clear page done");

    // R6: write during programming ignored
    writeByte(AW'(512), 8'h31); refMem[512] = 8'h31;
    repeat (50) @(negedge clk);
    writeByte(AW'(512), 8'hEE);
    check(rdyBusyLow == 1'b1, "R6 still busy", rdyBusyLow, 1);
    waitIdle("R6 page done");
    repeat (10) @(negedge clk);
    check(rdyBusyLow == 1'b0, "R6 no page from busy-time write", rdyBusyLow, 0);
    readAt(AW'(512), 8'h31, 1'b1, "R6 array unchanged");

    // R5: protect
    protN = 1'b0;
    repeat (4) @(negedge clk);
    writeByte(AW'(512), 8'h55);
    check(rdyBusyLow == 1'b0, "R5 protected write starts nothing", rdyBusyLow, 0);
    readAt(AW'(512), 8'h00, 1'b0, "R5 protected read");
    protN = 1'b1;
    repeat (4) @(negedge clk);
    readAt(AW'(512), 8'h31, 1'b1, "R5 array intact");

    // R9: inter-byte window violation
    writeByte(AW'(576), 8'h41); refMem[576] = 8'h41;
    @(negedge clk);
    addr = AW'(577); dIn = 8'h42; weN = 1'b0; ceN = 1'b0;
    repeat (80) @(negedge clk);
    weN = 1'b1; ceN = 1'b1;
    repeat (3) @(negedge clk);
    readAt(AW'(0), 8'hC1, 1'b1, "R9 poll shows last byte before window close");
    waitIdle("R9 page done");
    readAt(AW'(576), 8'h41, 1'b1, "R9 earlier byte stored");
    readAt(AW'(577), 8'h19, 1'b1, "R9 open byte discarded");

    repeat (10) @(negedge clk);
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule